// File: doc/BRIEF.md
# Ordered Team-Ending Barrier Controller

This block sits in each core of a chain of multithreaded cores and handles the moment a hardware thread (hart) commits its team-ending return. When the reorder logic of a hart reports that its oldest instruction is an ending return, the block decides what kind of ending it is. The decision uses two register values: the join address and the target identity. The four outcomes are:

- a plain end;
- a wait for a join address;
- a whole-run exit;
- a join, which sends the join address backward to the target hart.

The ending commits only when the hart holds the ending token. Commits therefore happen strictly in team order, which makes the block a barrier between a parallel team and the sequential code that follows it.

The token is a single bit per hart. It moves forward one hart per cycle on each commit. The last hart of the core passes it to the first hart of the next core, and the first hart takes it from the previous core. The first member of a team receives the token directly when the team starts. Join addresses that arrive on the backward link are held per hart. A hart that is waiting for a join restarts fetch at the held address once both the wait and the address are present.

Top module: `team_end_barrier`

## Requirements
- R1: After reset no hart holds the token or waits. `commitAck`, `tokenOut`, `joinSendValid`, `exitRun`, `hartWaiting` and `restartValid` are all low.
- R2: Hart h's `commitAck[h]` is high only in a cycle where `tailEnding[h]` is high and hart h holds the token. A hart without the token never commits, however long it requests.
- R3: At most one hart commits per cycle. When several eligible harts request, the lowest hart index commits first.
- R4: A commit by hart h (h below `NHARTS`-1) hands the token to hart h+1, which can commit in the following cycle at the earliest. The commit also removes the token from hart h.
- R5: A commit by the last hart drives `tokenOut` high in the same cycle. A cycle with `tokenIn` high gives hart 0 the token from the next cycle.
- R6: If the committing hart's join address is nonzero, `joinSendValid` is high in the commit cycle. `joinSendAddr` equals that join address and `joinSendDest` equals that hart's target identity. `exitRun` stays low.
- R7: If the join address is zero and the target identity is all ones, `exitRun` is high in the commit cycle and `joinSendValid` stays low.
- R8: If the join address is zero and the target identity equals the hart's own identity (`coreId`*`NHARTS`+h), hart h is reported in `hartWaiting` from the cycle after the commit.
- R9: If the join address is zero and the target identity is neither all ones nor the hart's own identity, the commit produces no join send, no exit and no wait.
- R10: A join address received on `joinRecvValid` for a hart is held. `restartValid[h]` is high for exactly one cycle, with `restartPcFlat` slice h equal to that address, in the first cycle where hart h both waits and holds an address. Both are cleared after that cycle. A held address produces no restart while the hart does not wait.
- R11: A `teamStart[h]` pulse gives hart h the token from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreId | input | CORE_W | Index of this core in the chain |
| teamStart | input | NHARTS | Pulse per hart: hart is a team's first member and takes the token |
| tailEnding | input | NHARTS | Per hart: oldest instruction is an ending return, held until acknowledged |
| raFlat | input | NHARTS*XLEN | Per-hart join address, hart h in slice h |
| t0Flat | input | NHARTS*XLEN | Per-hart target identity, hart h in slice h |
| tokenIn | input | 1 | Ending token from the previous core's last hart |
| tokenOut | output | 1 | Ending token to the next core's first hart |
| commitAck | output | NHARTS | One-hot0 commit of an ending return |
| joinSendValid | output | 1 | Join address sent backward this cycle |
| joinSendDest | output | XLEN | Identity of the hart that receives the join |
| joinSendAddr | output | XLEN | Join address being sent |
| exitRun | output | 1 | Whole run exits this cycle |
| joinRecvValid | input | 1 | Join address arriving for a local hart |
| joinRecvHart | input | HIDX_W | Local hart index of the arriving join |
| joinRecvAddr | input | XLEN | Arriving join address |
| hartWaiting | output | NHARTS | Harts waiting for a join address |
| restartValid | output | NHARTS | One-cycle fetch restart per hart |
| restartPcFlat | output | NHARTS*XLEN | Restart address per hart, hart h in slice h |

## Verification
A lost or duplicated token shows at the ports within one cycle of the next request. Either an eligible hart fails to raise `commitAck`, or a hart that never received the token commits. The chain test runs one request per hart and expects exactly one acknowledge per cycle in hart order, so a token that skips or stalls is visible in the cycle it goes wrong. A wrong ending-type decode shows in the commit cycle itself, as a missing or spurious join send or exit, or as a wait that appears the cycle after. A lost join buffer or a stuck wait shows one cycle later as a missing, repeated or mis-addressed restart pulse.

// File: rtl/teb_pkg.sv
package teb_pkg;

  // Ending classification of a committing hart
  typedef enum logic [1:0] {
    END_PLAIN = 2'd0,
    END_WAIT  = 2'd1,
    END_EXIT  = 2'd2,
    END_JOIN  = 2'd3
  } endKind_e;

  // Strobes from control to datapath for the current commit
  typedef struct packed {
    logic     fire;
    endKind_e kind;
  } endStrobe_t;

endpackage

// File: rtl/teb_kind_decode.sv
module teb_kind_decode
  import teb_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] joinAddr,
  input  logic [XLEN-1:0] targetId,
  input  logic [XLEN-1:0] ownId,
  output endKind_e        kind
);

  // A nonzero join address dominates; otherwise the target identity decides
  always_comb begin
    if (joinAddr != '0)             kind = END_JOIN;
    else if (targetId == '1)        kind = END_EXIT;
    else if (targetId == ownId)     kind = END_WAIT;
    else                            kind = END_PLAIN;
  end

endmodule

// File: rtl/teb_ctrl.sv
module teb_ctrl
  import teb_pkg::*;
#(
  parameter int NHARTS = 4,
  parameter int HIDX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NHARTS-1:0] teamStart,
  input  logic [NHARTS-1:0] tailEnding,
  input  logic              tokenIn,
  input  endKind_e          kindVec [NHARTS],
  input  logic [NHARTS-1:0] bufValid,
  output logic [NHARTS-1:0] grantOh,
  output logic [HIDX_W-1:0] grantIdx,
  output endStrobe_t        strobe,
  output logic              tokenOut,
  output logic [NHARTS-1:0] hartWaiting,
  output logic [NHARTS-1:0] wakeOh
);

  logic [NHARTS-1:0] tokenHeld;
  logic [NHARTS-1:0] waitState;
  logic [NHARTS-1:0] passIn;
  logic              anyGrant;

  // Lowest-index eligible hart wins the single commit slot
  always_comb begin
    grantOh  = '0;
    grantIdx = '0;
    anyGrant = 1'b0;
    for (int h = 0; h < NHARTS; h++) begin
      if (!anyGrant && tailEnding[h] && tokenHeld[h]) begin
        grantOh[h] = 1'b1;
        grantIdx   = HIDX_W'(h);
        anyGrant   = 1'b1;
      end
    end
  end

  assign strobe.fire = anyGrant;
  assign strobe.kind = kindVec[grantIdx];

  // Token arriving at each hart: previous core for hart 0, predecessor otherwise
  generate
    if (NHARTS > 1) begin : g_chain
      assign passIn = {grantOh[NHARTS-2:0], tokenIn};
    end else begin : g_single
      assign passIn = tokenIn;
    end
  endgenerate

  assign tokenOut    = grantOh[NHARTS-1];
  assign wakeOh      = waitState & bufValid;
  assign hartWaiting = waitState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tokenHeld <= '0;
      waitState <= '0;
    end else begin
      for (int h = 0; h < NHARTS; h++) begin
        if (teamStart[h] || passIn[h])                  tokenHeld[h] <= 1'b1;
        else if (grantOh[h])                            tokenHeld[h] <= 1'b0;

        if (grantOh[h] && strobe.kind == END_WAIT)      waitState[h] <= 1'b1;
        else if (wakeOh[h])                             waitState[h] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/teb_datapath.sv
module teb_datapath
  import teb_pkg::*;
#(
  parameter int NHARTS = 4,
  parameter int XLEN   = 32,
  parameter int HIDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NHARTS*XLEN-1:0] raFlat,
  input  logic [NHARTS*XLEN-1:0] t0Flat,
  input  logic [HIDX_W-1:0]      grantIdx,
  input  endStrobe_t             strobe,
  input  logic [NHARTS-1:0]      wakeOh,
  input  logic                   joinRecvValid,
  input  logic [HIDX_W-1:0]      joinRecvHart,
  input  logic [XLEN-1:0]        joinRecvAddr,
  output logic                   joinSendValid,
  output logic [XLEN-1:0]        joinSendDest,
  output logic [XLEN-1:0]        joinSendAddr,
  output logic                   exitRun,
  output logic [NHARTS-1:0]      bufValid,
  output logic [NHARTS-1:0]      restartValid,
  output logic [NHARTS*XLEN-1:0] restartPcFlat
);

  logic [XLEN-1:0] bufAddr [NHARTS];

  assign joinSendValid = strobe.fire && (strobe.kind == END_JOIN);
  assign exitRun       = strobe.fire && (strobe.kind == END_EXIT);
  assign joinSendAddr  = raFlat[grantIdx*XLEN +: XLEN];
  assign joinSendDest  = t0Flat[grantIdx*XLEN +: XLEN];
  assign restartValid  = wakeOh;

  generate
    for (genvar h = 0; h < NHARTS; h++) begin : g_buf
      assign restartPcFlat[h*XLEN +: XLEN] = bufAddr[h];

      // An arriving address is kept until the hart consumes it on restart
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bufValid[h] <= 1'b0;
          bufAddr[h]  <= '0;
        end else if (joinRecvValid && joinRecvHart == HIDX_W'(h)) begin
          bufValid[h] <= 1'b1;
          bufAddr[h]  <= joinRecvAddr;
        end else if (wakeOh[h]) begin
          bufValid[h] <= 1'b0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/team_end_barrier.sv
module team_end_barrier
  import teb_pkg::*;
#(
  parameter int NHARTS = 4,
  parameter int XLEN   = 32,
  parameter int CORE_W = 6,
  localparam int HIDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CORE_W-1:0]      coreId,
  input  logic [NHARTS-1:0]      teamStart,
  input  logic [NHARTS-1:0]      tailEnding,
  input  logic [NHARTS*XLEN-1:0] raFlat,
  input  logic [NHARTS*XLEN-1:0] t0Flat,
  input  logic                   tokenIn,
  output logic                   tokenOut,
  output logic [NHARTS-1:0]      commitAck,
  output logic                   joinSendValid,
  output logic [XLEN-1:0]        joinSendDest,
  output logic [XLEN-1:0]        joinSendAddr,
  output logic                   exitRun,
  input  logic                   joinRecvValid,
  input  logic [HIDX_W-1:0]      joinRecvHart,
  input  logic [XLEN-1:0]        joinRecvAddr,
  output logic [NHARTS-1:0]      hartWaiting,
  output logic [NHARTS-1:0]      restartValid,
  output logic [NHARTS*XLEN-1:0] restartPcFlat
);

  endKind_e          kindVec [NHARTS];
  endStrobe_t        strobe;
  logic [HIDX_W-1:0] grantIdx;
  logic [NHARTS-1:0] bufValid;
  logic [NHARTS-1:0] wakeOh;

  generate
    for (genvar h = 0; h < NHARTS; h++) begin : g_dec
      logic [XLEN-1:0] ownId;
      assign ownId = XLEN'(coreId) * XLEN'(NHARTS) + XLEN'(h);
      teb_kind_decode #(.XLEN(XLEN)) u_dec (
        .joinAddr (raFlat[h*XLEN +: XLEN]),
        .targetId (t0Flat[h*XLEN +: XLEN]),
        .ownId    (ownId),
        .kind     (kindVec[h])
      );
    end
  endgenerate

  teb_ctrl #(.NHARTS(NHARTS), .HIDX_W(HIDX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .teamStart   (teamStart),
    .tailEnding  (tailEnding),
    .tokenIn     (tokenIn),
    .kindVec     (kindVec),
    .bufValid    (bufValid),
    .grantOh     (commitAck),
    .grantIdx    (grantIdx),
    .strobe      (strobe),
    .tokenOut    (tokenOut),
    .hartWaiting (hartWaiting),
    .wakeOh      (wakeOh)
  );

  teb_datapath #(.NHARTS(NHARTS), .XLEN(XLEN), .HIDX_W(HIDX_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .raFlat        (raFlat),
    .t0Flat        (t0Flat),
    .grantIdx      (grantIdx),
    .strobe        (strobe),
    .wakeOh        (wakeOh),
    .joinRecvValid (joinRecvValid),
    .joinRecvHart  (joinRecvHart),
    .joinRecvAddr  (joinRecvAddr),
    .joinSendValid (joinSendValid),
    .joinSendDest  (joinSendDest),
    .joinSendAddr  (joinSendAddr),
    .exitRun       (exitRun),
    .bufValid      (bufValid),
    .restartValid  (restartValid),
    .restartPcFlat (restartPcFlat)
  );

endmodule

// File: rtl/teb_checker.sv
module teb_checker #(
  parameter int NHARTS = 4,
  parameter int XLEN   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [NHARTS-1:0] tailEnding,
  input logic [NHARTS-1:0] commitAck,
  input logic              joinSendValid,
  input logic [XLEN-1:0]   joinSendAddr,
  input logic              exitRun,
  input logic [NHARTS-1:0] hartWaiting,
  input logic [NHARTS-1:0] restartValid
);

  // R2: an acknowledge only answers a pending ending request
  assert_ack_needs_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    (commitAck & ~tailEnding) == '0);

  // R3: a single commit slot per cycle
  assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(commitAck));

  // R6: a join send carries a nonzero address and belongs to a commit
  assert_join_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    joinSendValid |-> (joinSendAddr != '0) && (commitAck != '0));

  // R7: exit belongs to a commit and never coincides with a join send
  assert_exit_alone_R7: assert property (@(posedge clk) disable iff (!rstN)
    exitRun |-> !joinSendValid && (commitAck != '0));

  // R8: a hart starts waiting only right after its own commit
  assert_wait_after_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hartWaiting & ~$past(hartWaiting) & ~$past(commitAck)) == '0);

  // R10: a restart pulse lasts one cycle and only for a waiting hart
  assert_restart_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (restartValid != '0) |=> ((restartValid & $past(restartValid)) == '0));

  assert_restart_waiting_R10: assert property (@(posedge clk) disable iff (!rstN)
    (restartValid & ~hartWaiting) == '0);

endmodule

bind team_end_barrier teb_checker #(.NHARTS(NHARTS), .XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .tailEnding    (tailEnding),
  .commitAck     (commitAck),
  .joinSendValid (joinSendValid),
  .joinSendAddr  (joinSendAddr),
  .exitRun       (exitRun),
  .hartWaiting   (hartWaiting),
  .restartValid  (restartValid)
);

// File: tb/tb_team_end_barrier.sv
`timescale 1ns/1ps
module tb_team_end_barrier;

  localparam int NH = 4;
  localparam int XL = 32;
  localparam int CW = 6;
  localparam int HW = 2;
  localparam logic [CW-1:0] CORE = 6'd5;  // own ids are 20..23

  localparam int K_PLAIN = 0, K_WAIT = 1, K_EXIT = 2, K_JOIN = 3;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NH-1:0]     teamStart, tailEnding, commitAck, hartWaiting, restartValid;
  logic [NH*XL-1:0]  raFlat, t0Flat, restartPcFlat;
  logic              tokenIn, tokenOut, joinSendValid, exitRun, joinRecvValid;
  logic [XL-1:0]     joinSendDest, joinSendAddr, joinRecvAddr;
  logic [HW-1:0]     joinRecvHart;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  team_end_barrier #(.NHARTS(NH), .XLEN(XL), .CORE_W(CW)) dut (
    .clk(clk), .rstN(rstN), .coreId(CORE), .teamStart(teamStart),
    .tailEnding(tailEnding), .raFlat(raFlat), .t0Flat(t0Flat),
    .tokenIn(tokenIn), .tokenOut(tokenOut), .commitAck(commitAck),
    .joinSendValid(joinSendValid), .joinSendDest(joinSendDest),
    .joinSendAddr(joinSendAddr), .exitRun(exitRun),
    .joinRecvValid(joinRecvValid), .joinRecvHart(joinRecvHart),
    .joinRecvAddr(joinRecvAddr), .hartWaiting(hartWaiting),
    .restartValid(restartValid), .restartPcFlat(restartPcFlat)
  );

  task automatic chk(input string req, input string what,
                     input logic [XL-1:0] act, input logic [XL-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [XL-1:0] ownId(input int h);
    return XL'(CORE) * NH + XL'(h);
  endfunction

  // Expected ending kind from the requirement text (R6..R9)
  function automatic int expKind(input logic [XL-1:0] ra, input logic [XL-1:0] t0, input int h);
    if (ra != 0)           return K_JOIN;
    if (t0 == '1)          return K_EXIT;
    if (t0 == ownId(h))    return K_WAIT;
    return K_PLAIN;
  endfunction

  task automatic nextCycle();
    @(negedge clk);
  endtask

  task automatic setRegs(input int h, input logic [XL-1:0] ra, input logic [XL-1:0] t0);
    raFlat[h*XL +: XL] = ra;
    t0Flat[h*XL +: XL] = t0;
  endtask

  // Push any stray tokens out of the core with plain endings
  task automatic drain();
    for (int h = 0; h < NH; h++) setRegs(h, '0, '0);
    tailEnding = '1;
    repeat (NH + 1) nextCycle();
    tailEnding = '0;
    nextCycle();
  endtask

  task automatic endOne(input int h, input logic [XL-1:0] ra, input logic [XL-1:0] t0,
                        input logic [XL-1:0] pc);
    int k;
    k = expKind(ra, t0, h);
    setRegs(h, ra, t0);
    teamStart = NH'(1) << h;
    nextCycle();
    teamStart = '0;
    tailEnding = NH'(1) << h;
    #1;
    chk("R11", "ack after team start", XL'(commitAck), XL'(NH'(1) << h));
    chk("R6", "join send valid", XL'(joinSendValid), XL'(k == K_JOIN));
    if (k == K_JOIN) begin
      chk("R6", "join addr", joinSendAddr, ra);
      chk("R6", "join dest", joinSendDest, t0);
    end
    chk("R7", "exit", XL'(exitRun), XL'(k == K_EXIT));
    nextCycle();
    tailEnding = '0;
    #1;
    chk("R8", "waiting after commit", XL'(hartWaiting[h]), XL'(k == K_WAIT));
    if (k == K_PLAIN) chk("R9", "plain leaves no wait", XL'(hartWaiting), 0);
    if (k == K_WAIT) begin
      joinRecvValid = 1'b1;
      joinRecvHart  = HW'(h);
      joinRecvAddr  = pc;
      nextCycle();
      joinRecvValid = 1'b0;
      #1;
      chk("R10", "restart pulse", XL'(restartValid), XL'(NH'(1) << h));
      chk("R10", "restart pc", restartPcFlat[h*XL +: XL], pc);
      nextCycle();
      #1;
      chk("R10", "restart ends", XL'(restartValid), 0);
      chk("R10", "wait cleared", XL'(hartWaiting), 0);
    end
    drain();
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; teamStart = '0; tailEnding = '0; raFlat = '0; t0Flat = '0;
    tokenIn = 1'b0; joinRecvValid = 1'b0; joinRecvHart = '0; joinRecvAddr = '0;
    repeat (3) nextCycle();
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "ack", XL'(commitAck), 0);
    chk("R1", "tokenOut", XL'(tokenOut), 0);
    chk("R1", "waiting", XL'(hartWaiting), 0);
    chk("R1", "restart", XL'(restartValid), 0);
    chk("R1", "join/exit", XL'({joinSendValid, exitRun}), 0);

    // R2: request without token never commits
    nextCycle();
    tailEnding = 4'b0010;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R2", "no token no ack", XL'(commitAck), 0);
      nextCycle();
    end
    tailEnding = '0;
    nextCycle();

    // R4/R5: token chain across all harts, one commit per cycle
    for (int h = 0; h < NH; h++) setRegs(h, '0, 32'h7);
    teamStart = 4'b0001;
    nextCycle();
    teamStart = '0;
    tailEnding = '1;
    for (int k = 0; k < NH; k++) begin
      #1;
      chk("R4", "chain ack order", XL'(commitAck), XL'(NH'(1) << k));
      chk("R5", "tokenOut on last", XL'(tokenOut), XL'(k == NH - 1));
      nextCycle();
      tailEnding[k] = 1'b0;
    end
    #1;
    chk("R4", "token gone after chain", XL'(commitAck), 0);
    tailEnding = '0;
    nextCycle();

    // R3: two token holders, lowest index first
    teamStart = 4'b1010;
    nextCycle();
    teamStart = '0;
    tailEnding = 4'b1010;
    #1;
    chk("R3", "lowest first", XL'(commitAck), 32'h2);
    nextCycle();
    tailEnding = 4'b1000;
    #1;
    chk("R3", "second next", XL'(commitAck), 32'h8);
    chk("R5", "tokenOut", XL'(tokenOut), 1);
    nextCycle();
    tailEnding = '0;
    drain();

    // R5: token from previous core reaches hart 0
    tokenIn = 1'b1;
    nextCycle();
    tokenIn = 1'b0;
    tailEnding = 4'b0001;
    #1;
    chk("R5", "tokenIn to hart0", XL'(commitAck), 32'h1);
    nextCycle();
    tailEnding = '0;
    drain();

    // Directed kinds on hart 2
    endOne(2, 32'h1234_5678, 32'h15, '0);
    endOne(2, '0, '1, '0);
    endOne(2, '0, ownId(2), 32'h0000_ABC0);
    endOne(2, '0, ownId(1), '0);

    // R10: address arrives before the wait
    joinRecvValid = 1'b1; joinRecvHart = 2'd1; joinRecvAddr = 32'hCAFE_0010;
    nextCycle();
    joinRecvValid = 1'b0;
    #1;
    chk("R10", "held without wait", XL'(restartValid), 0);
    nextCycle();
    #1;
    chk("R10", "still held", XL'(restartValid), 0);
    setRegs(1, '0, ownId(1));
    teamStart = 4'b0010;
    nextCycle();
    teamStart = '0;
    tailEnding = 4'b0010;
    #1;
    chk("R8", "wait commit", XL'(commitAck), 32'h2);
    nextCycle();
    tailEnding = '0;
    #1;
    chk("R10", "early addr restart", XL'(restartValid), 32'h2);
    chk("R10", "early addr pc", restartPcFlat[1*XL +: XL], 32'hCAFE_0010);
    nextCycle();
    #1;
    chk("R10", "one cycle only", XL'(restartValid), 0);
    drain();

    // Random endings
    for (int i = 0; i < 40; i++) begin
      int h, sel;
      logic [XL-1:0] ra, t0;
      h   = int'($urandom % NH);
      sel = int'($urandom % 4);
      ra  = '0;
      case (sel)
        K_JOIN:  begin ra = $urandom | 32'h1; t0 = $urandom; end
        K_EXIT:  t0 = '1;
        K_WAIT:  t0 = ownId(h);
        default: t0 = $urandom & 32'hF;
      endcase
      endOne(h, ra, t0, $urandom & 32'hFFFF_FFFC);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule